// File: doc/BRIEF.md
# Pin Request and Service Tracker

This block sits between a bank of interrupt input pins and the logic that sends interrupt messages. It samples every pin on each clock, keeps one request bit and one in-service bit per pin, and picks one pending pin per cycle for service. The highest-numbered eligible pin always goes first. A serviced pin that is unmasked produces a one-cycle delivery request carrying its pin number, its vector and its trigger mode. A level-triggered pin then stays in service until an end-of-interrupt names its vector.

Per-pin configuration (mask, trigger mode, vector) comes from a redirection table held outside the block and presented on flat buses. A global enable gates all input sampling. A sticky pending flag tells the host that some pin input changed; the host clears it with an acknowledge. An end-of-interrupt is matched back to a pin by searching the table for the lowest entry whose vector equals the one given. EOIs that cannot be applied raise a one-cycle error flag.

Top module: `pin_service_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dlv_valid`, `pend` and `eoi_err` are 0.
- R2: Pin 0 never raises a request or the pending flag. When `enable` is 0, or when a pin's `pin_mask` bit is 1 (masked), changes on that pin leave its request bit unchanged and do not raise `pend`.
- R3: For a pin with `pin_trig` bit 1 (level), the request bit equals the sampled input level on every clock. A pulse that goes low again before service leaves nothing to deliver.
- R4: For a pin with `pin_trig` bit 0 (edge), a sampled rising input sets the request bit. A low input never clears it, so a one-cycle pulse is delivered exactly once.
- R5: Any accepted change of a sampled pin level sets `pend` one cycle later. `ack` clears it. A new change in the same cycle as `ack` wins.
- R6: Each cycle without an EOI, the highest-numbered pin with its request set and its in-service bit clear is serviced. The service step clears that request. One cycle later, `dlv_valid` shows `dlv_pin`, the pin's vector from `pin_vec[pin*8 +: 8]`, and `dlv_level` equal to its trigger bit. Pins set together are served on consecutive cycles, in descending order.
- R7: A pin whose mask bit is 1 at its service step produces no delivery, yet its request bit is still cleared.
- R8: A serviced level pin sets its in-service bit and is not selected again, even with its input held high. A successful EOI clears that bit, and the pin is then delivered again if its input is still high.
- R9: An EOI vector matches the lowest-numbered entry with an equal vector, searching entries 0 to NUM_PINS-2 only. The last entry is never matched.
- R10: `eoi_err` pulses one cycle after an EOI that matches no entry, or whose matched pin is not in service. In that case no in-service bit changes.
- R11: In a cycle where `eoi_valid` is 1, no pin is serviced, so `dlv_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable for input sampling |
| pin_level | input | NUM_PINS | Interrupt input levels |
| pin_mask | input | NUM_PINS | Per-pin mask, 1 = masked |
| pin_trig | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| pin_vec | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W +: VEC_W |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VEC_W | Vector named by the end-of-interrupt |
| ack | input | 1 | Clears the pending flag |
| dlv_valid | output | 1 | Delivery request, one cycle |
| dlv_pin | output | $clog2(NUM_PINS) | Pin being delivered |
| dlv_vec | output | VEC_W | Vector of the delivered pin |
| dlv_level | output | 1 | Trigger mode of the delivered pin |
| pend | output | 1 | Sticky input-change flag |
| eoi_err | output | 1 | EOI could not be applied |

## Verification
The hardest case to reach is a pin that holds a request but is masked, or has already dropped, at the moment it is serviced. Normally service follows the request by a single clock. The stimulus holds an EOI strobe with an unmatched vector to stall service. While it is held, the stimulus raises the pin and then masks it, or raises a level pin and lowers it again. The stall is then released, and the stimulus confirms that nothing is delivered, either then or after unmasking. A second hard case is two table entries sharing a vector. The stimulus puts both in service and checks that one EOI releases only the lower-numbered pin, and that the last entry cannot be released at all.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int PST_PINS_DEF  = 24;
    localparam int PST_VEC_W_DEF = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

endpackage

// File: rtl/pst_pin_filter.sv
module pst_pin_filter
    import pst_pkg::*;
#(
    parameter int NUM_PINS = PST_PINS_DEF
) (
    input  logic                enable,
    input  logic [NUM_PINS-1:0] level,
    input  logic [NUM_PINS-1:0] prev,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] trig,
    input  logic [NUM_PINS-1:0] req_q,
    output logic [NUM_PINS-1:0] req_nx,
    output logic                any_change
);
    // Pin 0 is permanently excluded from sampling.
    localparam logic [NUM_PINS-1:0] LIVE = ~NUM_PINS'(1);

    logic [NUM_PINS-1:0] accept;
    logic [NUM_PINS-1:0] change;

    assign accept = LIVE & ~mask & {NUM_PINS{enable}};

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic rise;
        assign rise      = level[g] & ~prev[g];
        assign change[g] = accept[g] & (level[g] ^ prev[g]);
        always_comb begin
            if (!accept[g]) begin
                req_nx[g] = req_q[g];
            end else if (trig_e'(trig[g]) == TRIG_LEVEL) begin
                req_nx[g] = level[g];
            end else begin
                req_nx[g] = req_q[g] | rise;
            end
        end
    end

    assign any_change = |change;

endmodule

// File: rtl/pst_pick_high.sv
module pst_pick_high #(
    parameter int WIDTH = 24,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Later (higher) set bits overwrite earlier ones.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pst_eoi_match.sv
module pst_eoi_match #(
    parameter int ENTRIES = 23,
    parameter int VEC_W   = 8,
    parameter int IDX_W   = 5
) (
    input  logic [ENTRIES*VEC_W-1:0] table_vec,
    input  logic [VEC_W-1:0]         eoi_vec,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);
    // Scan downwards so the lowest matching entry is the last one written.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (table_vec[i*VEC_W +: VEC_W] == eoi_vec) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pin_service_tracker.sv
module pin_service_tracker
    import pst_pkg::*;
#(
    parameter int NUM_PINS = PST_PINS_DEF,
    parameter int VEC_W    = PST_VEC_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic [NUM_PINS-1:0]         pin_level,
    input  logic [NUM_PINS-1:0]         pin_mask,
    input  logic [NUM_PINS-1:0]         pin_trig,
    input  logic [NUM_PINS*VEC_W-1:0]   pin_vec,
    input  logic                        eoi_valid,
    input  logic [VEC_W-1:0]            eoi_vec,
    input  logic                        ack,
    output logic                        dlv_valid,
    output logic [$clog2(NUM_PINS)-1:0] dlv_pin,
    output logic [VEC_W-1:0]            dlv_vec,
    output logic                        dlv_level,
    output logic                        pend,
    output logic                        eoi_err
);
    localparam int PIN_W    = $clog2(NUM_PINS);
    localparam int SEARCHED = NUM_PINS - 1;

    typedef struct packed {
        logic [NUM_PINS-1:0] req;
        logic [NUM_PINS-1:0] isr;
        logic [NUM_PINS-1:0] prev;
        logic                pend;
        logic                dv;
        logic [PIN_W-1:0]    dp;
        logic [VEC_W-1:0]    dvec;
        logic                dlvl;
        logic                err;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_PINS-1:0] req_nx;
    logic                any_change;
    logic                pick_found;
    logic [PIN_W-1:0]    pick_idx;
    logic                eoi_hit;
    logic [PIN_W-1:0]    eoi_idx;

    pst_pin_filter #(.NUM_PINS(NUM_PINS)) u_filter (
        .enable     (enable),
        .level      (pin_level),
        .prev       (st_q.prev),
        .mask       (pin_mask),
        .trig       (pin_trig),
        .req_q      (st_q.req),
        .req_nx     (req_nx),
        .any_change (any_change)
    );

    pst_pick_high #(.WIDTH(NUM_PINS)) u_pick (
        .cand  (st_q.req & ~st_q.isr),
        .found (pick_found),
        .idx   (pick_idx)
    );

    pst_eoi_match #(.ENTRIES(SEARCHED), .VEC_W(VEC_W), .IDX_W(PIN_W)) u_eoi (
        .table_vec (pin_vec[SEARCHED*VEC_W-1:0]),
        .eoi_vec   (eoi_vec),
        .hit       (eoi_hit),
        .idx       (eoi_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_level;
        st_d.req  = req_nx;
        st_d.pend = any_change | (st_q.pend & ~ack);
        st_d.dv   = 1'b0;
        st_d.err  = 1'b0;
        if (eoi_valid) begin
            // EOI has the cycle; service waits.
            if (eoi_hit && st_q.isr[eoi_idx]) begin
                st_d.isr[eoi_idx] = 1'b0;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (pick_found) begin
            st_d.req[pick_idx] = 1'b0;
            st_d.dv            = ~pin_mask[pick_idx];
            st_d.dp            = pick_idx;
            st_d.dvec          = pin_vec[pick_idx*VEC_W +: VEC_W];
            st_d.dlvl          = pin_trig[pick_idx];
            if (trig_e'(pin_trig[pick_idx]) == TRIG_LEVEL) begin
                st_d.isr[pick_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dlv_valid = st_q.dv;
    assign dlv_pin   = st_q.dp;
    assign dlv_vec   = st_q.dvec;
    assign dlv_level = st_q.dlvl;
    assign pend      = st_q.pend;
    assign eoi_err   = st_q.err;

endmodule

// File: rtl/pin_service_tracker_chk.sv
module pin_service_tracker_chk #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        enable,
    input logic [NUM_PINS-1:0]         pin_mask,
    input logic                        eoi_valid,
    input logic                        ack,
    input logic                        dlv_valid,
    input logic [$clog2(NUM_PINS)-1:0] dlv_pin,
    input logic                        pend,
    input logic                        eoi_err
);
    AST_PIN0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_pin != '0); // R2
    AST_PEND_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(enable)); // R2
    AST_PEND_CLEARS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(ack)); // R5
    AST_DLV_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((($past(pin_mask) >> dlv_pin) & NUM_PINS'(1)) == '0)); // R7
    AST_ERR_FOLLOWS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |-> $past(eoi_valid)); // R10
    AST_EOI_STALLS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |=> !dlv_valid); // R11

endmodule

bind pin_service_tracker pin_service_tracker_chk #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pin_mask  (pin_mask),
    .eoi_valid (eoi_valid),
    .ack       (ack),
    .dlv_valid (dlv_valid),
    .dlv_pin   (dlv_pin),
    .pend      (pend),
    .eoi_err   (eoi_err)
);

// File: tb/test_pin_service_tracker.sv
module test_pin_service_tracker;
    localparam int N  = 24;
    localparam int VW = 8;
    localparam int PW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [N-1:0] lvl = '0, msk = '0, trg = '0;
    logic [VW-1:0] vtab [N];
    logic [N*VW-1:0] vbus;
    logic eoi_v = 1'b0;
    logic [VW-1:0] eoi_x = '0;
    logic ack = 1'b0;
    logic dlv_valid, dlv_level, pend, eoi_err;
    logic [PW-1:0] dlv_pin;
    logic [VW-1:0] dlv_vec;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) vbus[i*VW +: VW] = vtab[i];

    pin_service_tracker #(.NUM_PINS(N), .VEC_W(VW)) i_pin_service_tracker (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pin_level(lvl),
        .pin_mask(msk), .pin_trig(trg), .pin_vec(vbus), .eoi_valid(eoi_v),
        .eoi_vec(eoi_x), .ack(ack), .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
        .dlv_vec(dlv_vec), .dlv_level(dlv_level), .pend(pend), .eoi_err(eoi_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model, built from the requirements.
    logic [N-1:0] m_req, m_isr, m_prev;
    logic m_pend, e_valid, e_lvl, e_err;
    int e_pin;
    logic [VW-1:0] e_vec;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = '0; m_isr = '0; m_prev = '0; m_pend = 0;
            e_valid = 0; e_err = 0; e_pin = 0; e_vec = '0; e_lvl = 0;
        end else begin
            logic [N-1:0] nreq, cand;
            logic ev;
            int hit, pick;
            nreq = m_req; ev = 0;
            for (int i = 1; i < N; i++) begin
                if (enable && !msk[i]) begin
                    if (trg[i]) nreq[i] = lvl[i];
                    else if (lvl[i] && !m_prev[i]) nreq[i] = 1'b1;
                    if (lvl[i] != m_prev[i]) ev = 1;
                end
            end
            m_prev = lvl;
            m_pend = ev | (m_pend & !ack);
            e_valid = 0; e_err = 0;
            if (eoi_v) begin
                hit = -1;
                for (int i = N - 2; i >= 0; i--) if (vtab[i] == eoi_x) hit = i;
                if (hit >= 0 && m_isr[hit]) m_isr[hit] = 1'b0;
                else e_err = 1;
            end else begin
                cand = m_req & ~m_isr;
                pick = -1;
                for (int i = 0; i < N; i++) if (cand[i]) pick = i;
                if (pick >= 0) begin
                    nreq[pick] = 1'b0;
                    e_valid = !msk[pick];
                    e_pin = pick; e_vec = vtab[pick]; e_lvl = trg[pick];
                    if (trg[pick]) m_isr[pick] = 1'b1;
                end
            end
            m_req = nreq;
        end
    end

    // Delivery log and cycle-by-cycle comparison.
    int lg_n = 0;
    int lg_pin [64];

    always @(negedge clk) begin
        if (rst_n) begin
            chk(dlv_valid == e_valid, "R6 dlv_valid", dlv_valid, e_valid);
            if (e_valid) begin
                chk(dlv_pin == PW'(e_pin), "R6 dlv_pin", dlv_pin, e_pin);
                chk(dlv_vec == e_vec, "R6 dlv_vec", dlv_vec, e_vec);
                chk(dlv_level == e_lvl, "R6 dlv_level", dlv_level, e_lvl);
            end
            chk(pend == m_pend, "R5 pend", pend, m_pend);
            chk(eoi_err == e_err, "R10 eoi_err", eoi_err, e_err);
            if (dlv_valid) begin
                lg_pin[lg_n % 64] = int'(dlv_pin);
                lg_n++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_eoi(input logic [VW-1:0] v, output logic err);
        @(negedge clk); eoi_v = 1; eoi_x = v;
        @(negedge clk); eoi_v = 0; settle(); err = eoi_err;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic err;
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) vtab[i] = VW'(8'h20 + i);

        // R1: reset state
        tick(3); settle();
        chk(!dlv_valid && !pend && !eoi_err, "R1 outputs in reset", {dlv_valid, pend, eoi_err}, 0);
        rst_n = 1; enable = 1;
        tick(1); settle();
        chk(!dlv_valid && !pend && !eoi_err, "R1 first cycle", {dlv_valid, pend, eoi_err}, 0);

        // R2: pin 0, masked pin, disabled block
        lg_n = 0;
        lvl[0] = 1; tick(3); lvl[0] = 0; tick(3);
        msk[6] = 1; lvl[6] = 1; tick(3); lvl[6] = 0; tick(2); msk[6] = 0;
        enable = 0; lvl[8] = 1; tick(3); lvl[8] = 0; tick(2); enable = 1; tick(2);
        settle();
        chk(lg_n == 0, "R2 ignored pins deliver nothing", lg_n, 0);
        chk(pend == 0, "R2 ignored pins leave pend low", pend, 0);

        // R4: edge pulse delivered once
        lg_n = 0;
        lvl[11] = 1; tick(1); lvl[11] = 0; tick(5); settle();
        chk(lg_n == 1 && lg_pin[0] == 11, "R4 edge pulse delivered once", lg_n, 1);
        // R5: ack clears pend
        chk(pend == 1, "R5 pend after change", pend, 1);
        ack = 1; tick(1); ack = 0; settle();
        chk(pend == 0, "R5 pend cleared by ack", pend, 0);

        // R6: simultaneous edges served high to low
        lg_n = 0;
        lvl[5] = 1; lvl[17] = 1; lvl[9] = 1; tick(6); settle();
        chk(lg_n == 3 && lg_pin[0] == 17 && lg_pin[1] == 9 && lg_pin[2] == 5,
            "R6 descending order", lg_pin[0], 17);
        lvl[5] = 0; lvl[17] = 0; lvl[9] = 0; tick(2);

        // R3 and R11: level pulse gone before service during an EOI stall
        lg_n = 0; trg[4] = 1;
        eoi_v = 1; eoi_x = 8'hFF; tick(1);
        lvl[4] = 1; tick(1); lvl[4] = 0; tick(2); settle();
        chk(lg_n == 0, "R11 no service while EOI held", lg_n, 0);
        eoi_v = 0; tick(4); settle();
        chk(lg_n == 0, "R3 level request cleared when low", lg_n, 0);

        // R7: masked at service, request still cleared
        lg_n = 0;
        eoi_v = 1; eoi_x = 8'hFF; tick(1);
        lvl[10] = 1; tick(1); msk[10] = 1; tick(1);
        eoi_v = 0; tick(4); settle();
        chk(lg_n == 0, "R7 masked pin not delivered", lg_n, 0);
        msk[10] = 0; tick(4); settle();
        chk(lg_n == 0, "R7 request gone after masked service", lg_n, 0);
        lvl[10] = 0; tick(2);

        // R8: level pin held in service until EOI
        lg_n = 0; trg[7] = 1; lvl[7] = 1; tick(12); settle();
        chk(lg_n == 1, "R8 single delivery while in service", lg_n, 1);
        do_eoi(vtab[7], err);
        chk(err == 0, "R8 EOI accepted", err, 0);
        tick(3); settle();
        chk(lg_n == 2 && lg_pin[1] == 7, "R8 redelivered after EOI", lg_n, 2);
        lvl[7] = 0; do_eoi(vtab[7], err); tick(2);

        // R9: shared vector releases lowest entry; last entry unreachable
        lg_n = 0; vtab[3] = 8'h40; vtab[12] = 8'h40;
        trg[3] = 1; trg[12] = 1; lvl[3] = 1; lvl[12] = 1; tick(5); settle();
        chk(lg_n == 2 && lg_pin[0] == 12 && lg_pin[1] == 3, "R9 both served", lg_n, 2);
        do_eoi(8'h40, err); tick(3); settle();
        chk(err == 0 && lg_n == 3 && lg_pin[2] == 3, "R9 lowest entry released", lg_pin[2], 3);
        lg_n = 0; vtab[23] = 8'h77; trg[23] = 1; lvl[23] = 1; tick(4);
        do_eoi(8'h77, err);
        chk(err == 1, "R9 last entry never matched", err, 1);
        tick(3); settle();
        chk(lg_n == 1, "R9 last entry stays in service", lg_n, 1);

        // R10: unmatched and not-in-service EOIs
        do_eoi(8'h99, err);
        chk(err == 1, "R10 unmatched vector", err, 1);
        do_eoi(vtab[5], err);
        chk(err == 1, "R10 pin not in service", err, 1);

        // Random phase
        rst_n = 0; lvl = '0; msk = '0; trg = '0; tick(2); rst_n = 1;
        for (int i = 0; i < N; i++) vtab[i] = VW'(8'h20 + ($urandom % 16));
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            lvl ^= N'($urandom & $urandom & $urandom);
            if ($urandom % 16 == 0) msk = N'($urandom & $urandom);
            if ($urandom % 32 == 0) trg = N'($urandom);
            enable = ($urandom % 20) != 0;
            ack = ($urandom % 4) == 0;
            eoi_v = ($urandom % 6) == 0;
            eoi_x = ($urandom % 8 == 0) ? VW'($urandom) : vtab[$urandom % N];
        end
        @(negedge clk); eoi_v = 0; ack = 0; tick(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule